// File: doc/BRIEF.md
# Opcode-Selected Arithmetic-Logic Unit

This block takes two narrow unsigned operands and a three-bit operation code and produces one result word wide enough to hold a full product. The eight operations are addition, subtraction, a one-place left shift of the first operand, multiplication, boolean AND and OR of the operands, boolean negation of the first operand, and bitwise inversion of the first operand. Each operation is zero-extended into the result. The boolean operations treat any nonzero operand as true.

The operation itself is combinational. The result and a zero indicator are captured in an output register on each clock edge. Result and flag therefore appear one cycle after the operands and the code are presented. A synchronous active-high reset clears both outputs.

Top module: `alu_opsel`

## Requirements
- R1: After reset, and in the first cycle after reset is released, `res_q` is 0 and `zero_q` is 1.
- R2: Code 3'b000 gives (a + b) zero-extended to 8 bits. The carry lands in bit 4.
- R3: Code 3'b001 gives (a - b) mod 256. If a < b the result wraps, for example 0 - 1 = 8'hFF.
- R4: Code 3'b010 gives {a, 1'b0} zero-extended. The bit shifted out of the operand is kept in bit 4.
- R5: Code 3'b011 gives the full unsigned product a*b. The largest value is 15*15 = 225.
- R6: Code 3'b100 gives 1 when a and b are both nonzero, and 0 otherwise. Code 3'b101 gives 1 when either operand is nonzero, and 0 otherwise. Only bit 0 can be set.
- R7: Code 3'b110 gives 1 when a is zero, and 0 otherwise. Code 3'b111 gives ~a in bits 3:0 with bits 7:4 cleared. For codes 110 and 111, operand b has no effect on the result.
- R8: `zero_q` is 1 exactly when `res_q` is 0.
- R9: Each result appears on `res_q` one clock edge after its inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a | input | 4 | First operand |
| b | input | 4 | Second operand |
| op | input | 3 | Operation code |
| res_q | output | 8 | Registered result |
| zero_q | output | 1 | Registered zero indicator |

## Verification
The only state is the output register. A wrong value there shows at the ports one cycle after the inputs that produced it. A decode error for one operation shows as soon as that code is applied with operands that separate it from its neighbours. Examples are a wrapped subtraction, a product above 127, and b toggling under codes 110 and 111. A zero flag that drifts from the result word is visible in the same cycle as the bad result.

// File: rtl/alu_opsel_pkg.sv
package alu_opsel_pkg;
    parameter int OPW = 4;
    parameter int RESW = 2 * OPW;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_SHL  = 3'b010,
        OP_MUL  = 3'b011,
        OP_LAND = 3'b100,
        OP_LOR  = 3'b101,
        OP_LNOT = 3'b110,
        OP_INV  = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic [RESW-1:0] res;
        logic            zero;
    } alu_out_t;
endpackage

// File: rtl/alu_arith.sv
module alu_arith
    import alu_opsel_pkg::*;
#(
    parameter int W = OPW,
    localparam int RW = 2 * W
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [RW-1:0] sum,
    output logic [RW-1:0] diff,
    output logic [RW-1:0] shl,
    output logic [RW-1:0] prod
);
    logic [RW-1:0] ax;
    logic [RW-1:0] bx;

    always_comb begin
        ax   = {{W{1'b0}}, a};
        bx   = {{W{1'b0}}, b};
        sum  = ax + bx;
        diff = ax - bx;
        shl  = ax << 1;
        prod = ax * bx;
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_opsel_pkg::*;
#(
    parameter int W = OPW,
    localparam int RW = 2 * W
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [RW-1:0] land,
    output logic [RW-1:0] lor,
    output logic [RW-1:0] lnot,
    output logic [RW-1:0] inv
);
    logic a_true;
    logic b_true;

    always_comb begin
        a_true = |a;
        b_true = |b;
        land   = {{(RW-1){1'b0}}, a_true & b_true};
        lor    = {{(RW-1){1'b0}}, a_true | b_true};
        lnot   = {{(RW-1){1'b0}}, ~a_true};
        inv    = {{W{1'b0}}, ~a};
    end
endmodule

// File: rtl/alu_opsel.sv
module alu_opsel
    import alu_opsel_pkg::*;
#(
    parameter int W = OPW,
    localparam int RW = 2 * W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [2:0]    op,
    output logic [RW-1:0] res_q,
    output logic          zero_q
);
    logic [RW-1:0] sum, diff, shl, prod;
    logic [RW-1:0] land, lor, lnot, inv;

    alu_arith #(.W(W)) arith_i (
        .a(a), .b(b), .sum(sum), .diff(diff), .shl(shl), .prod(prod)
    );

    alu_logic #(.W(W)) logic_i (
        .a(a), .b(b), .land(land), .lor(lor), .lnot(lnot), .inv(inv)
    );

    typedef struct packed {
        logic [RW-1:0] res;
        logic          zero;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (alu_op_e'(op))
            OP_ADD:  st_d.res = sum;
            OP_SUB:  st_d.res = diff;
            OP_SHL:  st_d.res = shl;
            OP_MUL:  st_d.res = prod;
            OP_LAND: st_d.res = land;
            OP_LOR:  st_d.res = lor;
            OP_LNOT: st_d.res = lnot;
            OP_INV:  st_d.res = inv;
            default: st_d.res = '0;
        endcase
        st_d.zero = (st_d.res == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.res  <= '0;
            st_q.zero <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_q  = st_q.res;
    assign zero_q = st_q.zero;
endmodule

// File: rtl/alu_opsel_chk.sv
module alu_opsel_chk #(
    parameter int W = 4,
    localparam int RW = 2 * W
) (
    input logic          clk,
    input logic          rst,
    input logic [W-1:0]  a,
    input logic [W-1:0]  b,
    input logic [2:0]    op,
    input logic [RW-1:0] res_q,
    input logic          zero_q
);
    // R8
    zero_match_chk: assert property (@(posedge clk) disable iff (rst)
        zero_q == (res_q == '0));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (res_q == '0 && zero_q));

    // R6
    logic_bool_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b100 || op == 3'b101 || op == 3'b110) |=> (res_q[RW-1:1] == '0));

    // R7
    inv_high_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b111) |=> (res_q[RW-1:W] == '0 && res_q[W-1:0] == ~$past(a)));

    // R4
    shl_lsb_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b010) |=> (res_q[0] == 1'b0 && res_q[W:1] == $past(a)));

    // R2
    add_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 3'b000) |=> (res_q == RW'($past(a)) + RW'($past(b))));
endmodule

bind alu_opsel alu_opsel_chk #(.W(W)) chk_i (
    .clk(clk), .rst(rst), .a(a), .b(b), .op(op), .res_q(res_q), .zero_q(zero_q)
);

// File: tb/alu_opsel_tb_top.sv
module alu_opsel_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] a, b;
    logic [2:0] op;
    logic [7:0] res_q;
    logic       zero_q;
    int         n_chk = 0;
    int         n_err = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    alu_opsel dut_i (
        .clk(clk), .rst(rst), .a(a), .b(b), .op(op),
        .res_q(res_q), .zero_q(zero_q)
    );

    function automatic logic [7:0] model(input logic [2:0] o, input logic [3:0] x, input logic [3:0] y);
        logic [7:0] xx, yy;
        xx = {4'h0, x};
        yy = {4'h0, y};
        case (o)
            3'b000: return xx + yy;
            3'b001: return xx - yy;
            3'b010: return {3'b000, x, 1'b0};
            3'b011: return xx * yy;
            3'b100: return {7'd0, (x != 0) && (y != 0)};
            3'b101: return {7'd0, (x != 0) || (y != 0)};
            3'b110: return {7'd0, x == 0};
            default: return {4'h0, ~x};
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] o);
        case (o)
            3'b000: return "R2";
            3'b001: return "R3";
            3'b010: return "R4";
            3'b011: return "R5";
            3'b100, 3'b101: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string rq, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", rq, got, exp);
        end
    endtask

    // apply inputs at negedge, sample next negedge (one edge later, R9)
    task automatic run(input logic [2:0] o, input logic [3:0] x, input logic [3:0] y);
        logic [7:0] e;
        op = o; a = x; b = y;
        e = model(o, x, y);
        @(negedge clk);
        check(req_of(o), res_q, e);
        check("R8", {7'd0, zero_q}, {7'd0, e == 8'd0});
    endtask

    initial begin
        rst = 1'b1; a = 4'h5; b = 4'h3; op = 3'b011;
        repeat (3) @(negedge clk);
        check("R1", res_q, 8'h00);
        check("R1", {7'd0, zero_q}, 8'd1);
        rst = 1'b0;
        op = 3'b000; a = 4'h0; b = 4'h0;
        @(negedge clk);
        check("R1", res_q, 8'h00);
        // directed corners
        run(3'b000, 4'hF, 4'hF);   // R2 carry into bit 4
        run(3'b001, 4'h0, 4'h1);   // R3 wrap to FF
        run(3'b001, 4'h9, 4'h9);   // R3 zero
        run(3'b010, 4'hF, 4'h0);   // R4 keeps top bit
        run(3'b011, 4'hF, 4'hF);   // R5 225
        run(3'b100, 4'h8, 4'h0);   // R6
        run(3'b100, 4'h2, 4'h4);   // R6 bitwise would be 0
        run(3'b101, 4'h0, 4'h0);   // R6
        run(3'b101, 4'h0, 4'h1);   // R6
        run(3'b110, 4'h0, 4'hF);   // R7
        run(3'b110, 4'h0, 4'h0);   // R7 b ignored
        run(3'b111, 4'h0, 4'h5);   // R7
        run(3'b111, 4'h0, 4'hA);   // R7 b ignored
        run(3'b111, 4'hF, 4'h0);   // R7 and R8 zero
        // R9 back-to-back changes each cycle
        begin
            void'($urandom(32'd77));
            for (int i = 0; i < 400; i++) begin
                run(3'($urandom), 4'($urandom), 4'($urandom));
            end
        end
        // R1 reset mid-run
        rst = 1'b1; op = 3'b011; a = 4'hF; b = 4'hF;
        @(negedge clk);
        check("R1", res_q, 8'h00);
        check("R1", {7'd0, zero_q}, 8'd1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule